// File: doc/BRIEF.md
# Programmable Interval Timer With Reload

This block is a memory-mapped interval timer. A 16-bit divider counts every machine cycle (one clock) without pause, and an 8-bit counter advances at one of four rates tapped from that divider. When the counter steps past its maximum it takes its next value from a modulo register. It then raises a one-clock interrupt request, which is meant to feed the timer line (bit 2) of a pending-interrupt flag byte. Software sees four byte-wide registers through a simple strobe interface: read strobe, write strobe and a 2-bit select.

Inside the counter unit, a small state machine tracks the timer. In `ST_IDLE` counting is disabled. In `ST_COUNT` counting is enabled. In `ST_FIRE` an overflow has just reloaded the counter and the interrupt request is high. The transitions are:

- **overflow**: any state moves to `ST_FIRE`.
- **enable**: `ST_IDLE` moves to `ST_COUNT`.
- **disable**: `ST_COUNT` moves to `ST_IDLE`.
- **retire**: `ST_FIRE` moves to `ST_COUNT` or `ST_IDLE`, according to the enable bit.

The counter advances on the falling edge of the selected divider bit ANDed with the enable bit. Clearing the divider or dropping the enable while that bit is high therefore adds one count.

Top module: `ivl_timer`

## Requirements
- R1: After reset the divider, counter, modulo and control registers read 0x00 and `irq` is low.
- R2: The divider adds one every clock; register select 0 reads its upper 8 bits.
- R3: Any write to select 0 clears the whole 16-bit divider to zero, whatever the data byte.
- R4: Select 1 is the counter, select 2 the modulo and select 3 the control register; all read back what was written, except control bits 7:3, which read as zero.
- R5: Control bits 1:0 pick the count period in clocks: 00 gives 256, 01 gives 4, 10 gives 16 and 11 gives 64. Measured from a divider clear, the k-th increment lands at divider value k times the period.
- R6: With control bit 2 at 0, the counter holds its value.
- R7: An increment from 0xFF loads the modulo value into the counter. `irq` is then high for exactly the following clock.
- R8: A counter write in the same cycle as an overflowing increment wins: the counter takes the written byte and no interrupt is raised.
- R9: An increment happens on every falling edge of (selected divider bit AND enable). Clearing the divider, or clearing the enable, while that bit is high adds one count.
- R10: `rd_data` is 0x00 whenever `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Machine-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 2 | Register select: 0 divider, 1 counter, 2 modulo, 3 control |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, combinational from select |
| irq | output | 1 | One-clock timer interrupt request |

## Verification
The bench builds the block with its default parameters: an 8-bit data path, a 16-bit divider and tap exponents 8, 2, 4 and 6. The 4-clock rate brings repeated overflows within a few dozen cycles, including back-to-back reloads with the modulo at 0xFE and 0xFF. The 256-clock rate is covered across two full periods, and the divider read is checked up to its second upper-byte step. The exact-edge cases are placed by clearing the divider and counting cycles from there: a write colliding with an overflow, a divider clear while the tap is high, and a disable while the tap is high.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;

    typedef enum logic [1:0] {
        REG_DIV = 2'd0,
        REG_CNT = 2'd1,
        REG_MOD = 2'd2,
        REG_CTL = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_FIRE  = 2'd2
    } tmr_state_e;

    localparam int CTL_W      = 3;
    localparam int CTL_EN_BIT = 2;
    localparam int RATE_W     = 2;
    localparam int NUM_RATES  = 1 << RATE_W;

endpackage

// File: rtl/ivl_timer_div.sv
module ivl_timer_div
    import ivl_timer_pkg::*;
#(
    parameter int DIV_W      = 16,
    parameter int DAT_W      = 8,
    parameter int RATE0_LOG2 = 8,
    parameter int RATE1_LOG2 = 2,
    parameter int RATE2_LOG2 = 4,
    parameter int RATE3_LOG2 = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [RATE_W-1:0] rate,
    output logic [DAT_W-1:0]  div_hi,
    output logic              tick
);

    localparam int LOG2S [NUM_RATES] = '{RATE0_LOG2, RATE1_LOG2, RATE2_LOG2, RATE3_LOG2};

    logic [DIV_W-1:0]     div_q;
    logic [NUM_RATES-1:0] taps;
    logic                 sel_now;
    logic                 sel_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clr) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_tap
        assign taps[g] = div_q[LOG2S[g]-1];
    end

    assign sel_now = taps[rate] & en;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= 1'b0;
        end else begin
            sel_q <= sel_now;
        end
    end

    assign tick   = sel_q & ~sel_now;
    assign div_hi = div_q[DIV_W-1 -: DAT_W];

    assert_div_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> div_q == $past(div_q) + 1'b1);

    assert_div_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> div_q == '0);

    assert_tick_gap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);

endmodule

// File: rtl/ivl_timer_cnt.sv
module ivl_timer_cnt
    import ivl_timer_pkg::*;
#(
    parameter int DAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             en,
    input  logic             wr_cnt,
    input  logic             wr_mod,
    input  logic [DAT_W-1:0] wdata,
    output logic [DAT_W-1:0] cnt,
    output logic [DAT_W-1:0] mod,
    output logic             irq
);

    localparam logic [DAT_W-1:0] CNT_MAX = '1;

    tmr_state_e       st_q, st_d;
    logic [DAT_W-1:0] cnt_q, mod_q;
    logic             ovf;

    assign ovf = tick && (cnt_q == CNT_MAX) && !wr_cnt;

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (ovf) st_d = ST_FIRE; else if (en) st_d = ST_COUNT;
            ST_COUNT: if (ovf) st_d = ST_FIRE; else if (!en) st_d = ST_IDLE;
            ST_FIRE:  if (ovf) st_d = ST_FIRE; else if (en) st_d = ST_COUNT; else st_d = ST_IDLE;
            default:  st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            mod_q <= '0;
        end else begin
            if (wr_mod) begin
                mod_q <= wdata;
            end
            if (wr_cnt) begin
                cnt_q <= wdata;
            end else if (ovf) begin
                cnt_q <= mod_q;
            end else if (tick) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    always_comb begin
        irq = (st_q == ST_FIRE);
        cnt = cnt_q;
        mod = mod_q;
    end

    assert_reload_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && cnt_q == CNT_MAX && !wr_cnt) |=> (cnt_q == $past(mod_q)) && irq);

    assert_irq_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_cnt) |=> $stable(cnt_q));

    assert_wr_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> (cnt_q == $past(wdata)) && !irq);

endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
    import ivl_timer_pkg::*;
#(
    parameter int DAT_W      = 8,
    parameter int DIV_W      = 16,
    parameter int RATE0_LOG2 = 8,
    parameter int RATE1_LOG2 = 2,
    parameter int RATE2_LOG2 = 4,
    parameter int RATE3_LOG2 = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             rd_en,
    input  logic [1:0]       addr,
    input  logic [DAT_W-1:0] wr_data,
    output logic [DAT_W-1:0] rd_data,
    output logic             irq
);

    reg_sel_e         sel;
    logic             wr_div, wr_cnt, wr_mod, wr_ctl;
    logic [CTL_W-1:0] ctl_q;
    logic [DAT_W-1:0] div_hi, cnt, mod;
    logic             tick;

    assign sel    = reg_sel_e'(addr);
    assign wr_div = wr_en && (sel == REG_DIV);
    assign wr_cnt = wr_en && (sel == REG_CNT);
    assign wr_mod = wr_en && (sel == REG_MOD);
    assign wr_ctl = wr_en && (sel == REG_CTL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (wr_ctl) begin
            ctl_q <= wr_data[CTL_W-1:0];
        end
    end

    ivl_timer_div #(
        .DIV_W      (DIV_W),
        .DAT_W      (DAT_W),
        .RATE0_LOG2 (RATE0_LOG2),
        .RATE1_LOG2 (RATE1_LOG2),
        .RATE2_LOG2 (RATE2_LOG2),
        .RATE3_LOG2 (RATE3_LOG2)
    ) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (wr_div),
        .en     (ctl_q[CTL_EN_BIT]),
        .rate   (ctl_q[RATE_W-1:0]),
        .div_hi (div_hi),
        .tick   (tick)
    );

    ivl_timer_cnt #(
        .DAT_W (DAT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .en     (ctl_q[CTL_EN_BIT]),
        .wr_cnt (wr_cnt),
        .wr_mod (wr_mod),
        .wdata  (wr_data),
        .cnt    (cnt),
        .mod    (mod),
        .irq    (irq)
    );

    always_comb begin
        rd_data = '0;
        if (rd_en) begin
            unique case (sel)
                REG_DIV: rd_data = div_hi;
                REG_CNT: rd_data = cnt;
                REG_MOD: rd_data = mod;
                REG_CTL: rd_data = DAT_W'(ctl_q);
                default: rd_data = '0;
            endcase
        end
    end

    assert_ctl_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && sel == REG_CTL) |-> rd_data[DAT_W-1:CTL_W] == '0);

    assert_rd_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> rd_data == '0);

endmodule

// File: tb/ivl_timer_bench.sv
module ivl_timer_bench;

    localparam int CLK_P = 10;

    typedef struct packed {
        logic [1:0]  rate;
        logic        en;
        logic [7:0]  modv;
        logic [7:0]  start;
        logic [11:0] wt;
        logic [7:0]  exp_c;
        logic [3:0]  exp_i;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{2'b01, 1'b1, 8'h00, 8'h10, 12'd41,  8'h1A, 4'd0},
        '{2'b01, 1'b1, 8'hF0, 8'hFD, 12'd23,  8'hF3, 4'd1},
        '{2'b10, 1'b1, 8'h80, 8'hFE, 12'd63,  8'h82, 4'd1},
        '{2'b11, 1'b1, 8'h05, 8'hFF, 12'd200, 8'h07, 4'd1},
        '{2'b00, 1'b1, 8'h00, 8'h40, 12'd600, 8'h42, 4'd0},
        '{2'b01, 1'b1, 8'hFE, 8'hFE, 12'd23,  8'hFE, 4'd3},
        '{2'b01, 1'b1, 8'hFF, 8'hFF, 12'd11,  8'hFF, 4'd3},
        '{2'b01, 1'b0, 8'h00, 8'h33, 12'd50,  8'h33, 4'd0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int  errors = 0;
    int  checks = 0;
    bit  done = 1'b0;

    ivl_timer u_ivl_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .rd_en   (rd_en),
        .addr    (addr),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .irq     (irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] v);
        rd_en = 1'b1; addr = a;
        #1;
        v = rd_data;
        rd_en = 1'b0;
    endtask

    // Leaves the bench at the negedge of the cycle in which the divider reads 2
    task automatic setup(input logic [1:0] rate, input logic en,
                         input logic [7:0] modv, input logic [7:0] start);
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd2, modv);
        bus_wr(2'd0, 8'h00);
        bus_wr(2'd1, start);
        bus_wr(2'd3, {5'b0, en, rate});
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int n_irq;
        string tag;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values
        check("R1 irq", int'(irq), 0);
        bus_rd(2'd0, v); check("R1 div", v, 8'h00);
        bus_rd(2'd1, v); check("R1 cnt", v, 8'h00);
        bus_rd(2'd2, v); check("R1 mod", v, 8'h00);
        bus_rd(2'd3, v); check("R1 ctl", v, 8'h00);
        // R10: idle read data
        #1; check("R10 idle rd_data", rd_data, 8'h00);

        // R3: divider write clears regardless of data
        @(negedge clk);
        bus_wr(2'd0, 8'hAB);
        bus_rd(2'd0, v); check("R3 div clear", v, 8'h00);
        // R2: upper byte of a per-clock count
        repeat (300) @(negedge clk);
        bus_rd(2'd0, v); check("R2 div 300", v, 8'h01);
        repeat (212) @(negedge clk);
        bus_rd(2'd0, v); check("R2 div 512", v, 8'h02);

        // R4: register read-back
        bus_wr(2'd3, 8'hFF);
        bus_rd(2'd3, v); check("R4 ctl upper zero", v, 8'h07);
        bus_wr(2'd3, 8'h00);
        bus_wr(2'd2, 8'hA5);
        bus_rd(2'd2, v); check("R4 mod", v, 8'hA5);
        bus_wr(2'd1, 8'h3C);
        bus_rd(2'd1, v); check("R4 cnt", v, 8'h3C);

        // Vector table: R5 rates, R6 hold, R7 reload and interrupt
        for (int i = 0; i < NV; i++) begin
            setup(VEC[i].rate, VEC[i].en, VEC[i].modv, VEC[i].start);
            n_irq = 0;
            for (int k = 0; k < int'(VEC[i].wt); k++) begin
                @(negedge clk);
                if (irq) n_irq++;
            end
            if (!VEC[i].en) tag = "R6 hold";
            else if (VEC[i].exp_i != 0) tag = "R7 reload";
            else tag = "R5 rate";
            bus_rd(2'd1, v);
            check($sformatf("%s vec%0d cnt", tag, i), v, VEC[i].exp_c);
            check($sformatf("R7 vec%0d irq pulses", i), n_irq, int'(VEC[i].exp_i));
        end

        // R8: counter write collides with an overflowing increment
        setup(2'b01, 1'b1, 8'h20, 8'hFF);
        @(negedge clk);
        @(negedge clk);
        bus_wr(2'd1, 8'h55);
        check("R8 no irq", int'(irq), 0);
        bus_rd(2'd1, v); check("R8 write wins", v, 8'h55);

        // R9: divider clear while the tap is high adds one
        setup(2'b01, 1'b1, 8'h00, 8'h10);
        bus_wr(2'd0, 8'h00);
        @(negedge clk);
        bus_rd(2'd1, v); check("R9 div clear edge", v, 8'h11);

        // R9: disable while the tap is high adds one, then R6 holds
        setup(2'b01, 1'b1, 8'h00, 8'h20);
        bus_wr(2'd3, 8'h01);
        @(negedge clk);
        bus_rd(2'd1, v); check("R9 disable edge", v, 8'h21);
        repeat (40) @(negedge clk);
        bus_rd(2'd1, v); check("R6 held after disable", v, 8'h21);

        finish_run();
    end

endmodule